// File: doc/BRIEF.md
# Four-Instruction Accumulator Processor

This block is a very small processor built around a single 8-bit accumulator. It works from a 64-byte memory reached through one port. The port has an address output, a read-data input, a write-data output and a write strobe. The memory returns read data combinationally for the address driven in the same cycle, and it captures a write on the rising clock edge while the strobe is high.

Every instruction is one byte and runs in two cycles. In the first cycle the processor reads the instruction word at the program counter. In the second cycle it uses the address field of that word as its only operand address. There are four operations:

- an add into the accumulator;
- a NOR into the accumulator;
- a store of the accumulator;
- a jump that is taken only while the carry flag is clear.

The carry flag is the only condition state. Adds set it, and every jump clears it afterwards. Because the jump always clears the carry, a program can build unconditional jumps and loops from pairs of conditional jumps.

Top module: `tac_cpu`

## Requirements
- R1: While reset is held, the program counter, the accumulator and the carry are zero, the write strobe is low and the memory address is 0. After reset is released, the first instruction is fetched from address 0.
- R2: An instruction word carries its opcode in bits [7:6] and its operand address in bits [5:0]. The opcodes are 00 NOR, 01 ADD, 10 STA and 11 JCC.
- R3: Fetch and execute cycles strictly alternate. A fetch drives the program counter onto the address bus, captures the instruction word and advances the program counter by one, wrapping from 63 to 0.
- R4: ADD replaces the accumulator with (accumulator + memory operand) mod 256 and sets the carry to the carry-out of that sum.
- R5: NOR replaces the accumulator with the bitwise NOR of the accumulator and the memory operand, and leaves the carry unchanged.
- R6: STA raises the write strobe for exactly its execute cycle, with the operand address on the address bus and the accumulator on the write data. The strobe is never high at any other time.
- R7: JCC with the carry clear loads the program counter with its operand address, so the next fetch comes from that address.
- R8: JCC with the carry set does not jump, so the next fetch comes from the following address. In both cases JCC leaves the carry cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mem_addr | output | ADDR_W (6) | Memory address for the fetch or the operand access |
| mem_rdata | input | DATA_W (8) | Read data for the current mem_addr |
| mem_wdata | output | DATA_W (8) | Write data (the accumulator) |
| mem_we | output | 1 | Write strobe, high only during an STA execute cycle |

## Verification
The assertions check on every cycle that fetch and execute alternate, that a fetch advances the program counter, and that ADD, NOR and JCC each update the carry as required. They also check that a taken jump reloads the program counter, and that the write strobe appears only for a store, carrying the accumulator to the operand address.

Two things only the bench's programs can show: that a whole instruction sequence produces the right stored bytes in the right order, and that a jump skips code that must not run. Those programs also cover an add that overflows, a NOR that must keep a set carry, a program counter that wraps past the top of memory, and a reset applied part way through a run.

// File: rtl/tac_pkg.sv
package tac_pkg;

  localparam int OP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NOR = 2'b00,
    OP_ADD = 2'b01,
    OP_STA = 2'b10,
    OP_JCC = 2'b11
  } op_e;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_EXEC  = 1'b1
  } phase_e;

endpackage

// File: rtl/tac_rst_sync.sv
module tac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/tac_alu.sv
module tac_alu
  import tac_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  logic [DATA_W:0] sum;

  always_comb begin
    sum  = {1'b0, a} + {1'b0, b};
    res  = a;
    cout = cin;
    case (op)
      OP_ADD: begin
        res  = sum[DATA_W-1:0];
        cout = sum[DATA_W];
      end
      OP_NOR: begin
        res  = ~(a | b);
        cout = cin;
      end
      default: begin
        res  = a;
        cout = cin;
      end
    endcase
  end

endmodule

// File: rtl/tac_ctrl.sv
module tac_ctrl
  import tac_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int DATA_W = ADDR_W + OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              carry,
  output phase_e            phase,
  output op_e               op,
  output logic [ADDR_W-1:0] ir_addr,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              acc_en,
  output logic              carry_en
);

  phase_e            phase_q, phase_d;
  logic [DATA_W-1:0] ir_q;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              ir_en, pc_en;
  logic              in_fetch, in_exec;

  assign op      = op_e'(ir_q[DATA_W-1 -: OP_W]);
  assign ir_addr = ir_q[ADDR_W-1:0];

  // next-state and enables
  always_comb begin
    in_fetch = (phase_q == PH_FETCH);
    in_exec  = (phase_q == PH_EXEC);
    phase_d  = in_fetch ? PH_EXEC : PH_FETCH;
    ir_en    = in_fetch;
    pc_en    = in_fetch || (in_exec && op == OP_JCC && !carry);
    pc_d     = in_fetch ? (pc_q + ADDR_W'(1)) : ir_addr;
    mem_addr = in_fetch ? pc_q : ir_addr;
    mem_we   = in_exec && (op == OP_STA);
    acc_en   = in_exec && (op == OP_ADD || op == OP_NOR);
    carry_en = in_exec && (op == OP_ADD || op == OP_JCC);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
    end else begin
      phase_q <= phase_d;
      if (pc_en) pc_q <= pc_d;
      if (ir_en) ir_q <= mem_rdata;
    end
  end

  assign phase = phase_q;
  assign pc    = pc_q;

endmodule

// File: rtl/tac_datapath.sv
module tac_datapath
  import tac_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic              acc_en,
  input  logic              carry_en,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_cout,
  output logic [DATA_W-1:0] acc,
  output logic              carry
);

  logic [DATA_W-1:0] acc_q;
  logic              carry_q, carry_d;

  // the jump always leaves the flag clear
  always_comb begin
    carry_d = (op == OP_JCC) ? 1'b0 : alu_cout;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      if (acc_en)   acc_q   <= alu_res;
      if (carry_en) carry_q <= carry_d;
    end
  end

  assign acc   = acc_q;
  assign carry = carry_q;

endmodule

// File: rtl/tac_cpu.sv
module tac_cpu
  import tac_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int RST_STAGES = 2,
  localparam int DATA_W = ADDR_W + OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we
);

  logic              rst_sync_n;
  phase_e            phase;
  op_e               op;
  logic [ADDR_W-1:0] ir_addr;
  logic [ADDR_W-1:0] pc;
  logic              acc_en, carry_en;
  logic [DATA_W-1:0] acc, alu_res;
  logic              carry, alu_cout;

  tac_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  tac_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mem_rdata (mem_rdata),
    .carry     (carry),
    .phase     (phase),
    .op        (op),
    .ir_addr   (ir_addr),
    .pc        (pc),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .acc_en    (acc_en),
    .carry_en  (carry_en)
  );

  tac_alu #(.DATA_W(DATA_W)) u_alu (
    .op   (op),
    .a    (acc),
    .b    (mem_rdata),
    .cin  (carry),
    .res  (alu_res),
    .cout (alu_cout)
  );

  tac_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .op       (op),
    .acc_en   (acc_en),
    .carry_en (carry_en),
    .alu_res  (alu_res),
    .alu_cout (alu_cout),
    .acc      (acc),
    .carry    (carry)
  );

  assign mem_wdata = acc;

endmodule

// File: rtl/tac_cpu_chk.sv
module tac_cpu_chk
  import tac_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int DATA_W = ADDR_W + OP_W
) (
  input logic              clk,
  input logic              rst_n,
  input phase_e            phase,
  input op_e               op,
  input logic [ADDR_W-1:0] ir_addr,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] acc,
  input logic              carry,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we
);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_state_r1: assert (pc == '0 && acc == '0 && !carry && !mem_we && mem_addr == '0);
    end
  end

  p_alternate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FETCH) |=> (phase == PH_EXEC));

  p_exec_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC) |=> (phase == PH_FETCH));

  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FETCH) |=> (pc == $past(pc) + ADDR_W'(1)));

  p_add_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && op == OP_ADD) |=>
      ({carry, acc} == ({1'b0, $past(acc)} + {1'b0, $past(mem_rdata)})));

  p_nor_keeps_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && op == OP_NOR) |=> (carry == $past(carry)));

  p_we_only_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (phase == PH_EXEC && op == OP_STA));

  p_store_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == acc && mem_addr == ir_addr));

  p_jump_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && op == OP_JCC && !carry) |=> (pc == $past(ir_addr)));

  p_jump_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && op == OP_JCC) |=> !carry);

endmodule

bind tac_cpu tac_cpu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .phase     (phase),
  .op        (op),
  .ir_addr   (ir_addr),
  .pc        (pc),
  .acc       (acc),
  .carry     (carry),
  .mem_addr  (mem_addr),
  .mem_rdata (mem_rdata),
  .mem_wdata (mem_wdata),
  .mem_we    (mem_we)
);

// File: tb/sim_tac_cpu.sv
module sim_tac_cpu;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;

  logic [DW-1:0] mem [DEPTH];
  logic [AW+DW-1:0] exp_q [$];

  int n_checks;
  int n_fail;
  int cycles;

  tac_cpu #(.ADDR_W(AW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_q.push_back({a, d});
  endtask

  // monitor: every store is compared against the scoreboard queue (R6)
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected store", int'(mem_addr), 0);
      end else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        check({mem_addr, mem_wdata} == e, "R6 store addr/data",
              int'({mem_addr, mem_wdata}), int'(e));
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual %0d expected <150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  endtask

  task automatic load_prog_a();
    clear_mem();
    mem[0]  = 8'h54; mem[1]  = 8'h55; mem[2]  = 8'h9E; mem[3]  = 8'h56;
    mem[4]  = 8'h9F; mem[5]  = 8'hC9; mem[6]  = 8'hA0; mem[7]  = 8'hCA;
    mem[8]  = 8'hA1; mem[9]  = 8'hA1; mem[10] = 8'h17; mem[11] = 8'hA2;
    mem[12] = 8'h18; mem[13] = 8'h59; mem[14] = 8'h18; mem[15] = 8'hD3;
    mem[16] = 8'hA3; mem[17] = 8'hD1; mem[18] = 8'hD2; mem[19] = 8'hA1;
    mem[20] = 8'h05; mem[21] = 8'h03; mem[22] = 8'hFF; mem[23] = 8'h0F;
    mem[24] = 8'h00; mem[25] = 8'hF1;
  endtask

  task automatic push_prog_a();
    expect_write(6'd30, 8'h08);  // R4 plain add
    expect_write(6'd31, 8'h07);  // R4 overflowed add
    expect_write(6'd32, 8'h07);  // R8 jump not taken
    expect_write(6'd34, 8'hF0);  // R5 nor
    expect_write(6'd35, 8'hFF);  // R5 carry kept, R8 not taken
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0;
    exp_q.delete();
    repeat (3) @(negedge clk);
  endtask

  task automatic check_reset(input string tag);
    check(mem_addr == '0, tag, int'(mem_addr), 0);
    check(mem_we == 1'b0, tag, int'(mem_we), 0);
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    cycles   = 0;
    rst_n    = 1'b1;
    clear_mem();
    #2 rst_n = 1'b0;

    // program A: add, overflow, both jump outcomes, nor
    load_prog_a();
    repeat (3) @(negedge clk);
    check_reset("R1 reset bus");
    push_prog_a();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(mem_addr == 6'd1 || mem_addr == 6'd20 || mem_addr == 6'd0,
          "R1 starts at address 0", int'(mem_addr), 0);
    repeat (200) @(negedge clk);
    check(exp_q.size() == 0, "R6 all stores seen", exp_q.size(), 0);
    check(mem[30] == 8'h08, "R4 add result", int'(mem[30]), 8'h08);
    check(mem[31] == 8'h07, "R4 add wraps mod 256", int'(mem[31]), 8'h07);
    check(mem[32] == 8'h07, "R8 jump with carry set falls through", int'(mem[32]), 8'h07);
    check(mem[33] == 8'h00, "R7 taken jump skips code", int'(mem[33]), 0);
    check(mem[34] == 8'hF0, "R5 nor result", int'(mem[34]), 8'hF0);
    check(mem[35] == 8'hFF, "R5 nor keeps carry", int'(mem[35]), 8'hFF);
    check(mem_addr == 6'd17, "R7 halt loop fetch", int'(mem_addr), 17);
    @(negedge clk);
    check(mem_addr == 6'd17, "R7 halt loop exec", int'(mem_addr), 17);
    check(mem_we == 1'b0, "R6 no strobe while looping", int'(mem_we), 0);

    // program B: jump near top, PC wrap 63 -> 0, R2 opcode fields
    enter_reset();
    check_reset("R1 second reset");
    clear_mem();
    mem[0]  = 8'hFD;
    mem[1]  = 8'hAA;
    mem[2]  = 8'hC2;
    mem[61] = 8'h68;
    mem[62] = 8'h68;
    mem[63] = 8'hA9;
    mem[40] = 8'h81;
    expect_write(6'd41, 8'h02);  // R3 store at top before wrap
    expect_write(6'd42, 8'h02);  // R3 wrapped to 0, R8 not taken
    rst_n = 1'b1;
    repeat (200) @(negedge clk);
    check(exp_q.size() == 0, "R3 wrap stores seen", exp_q.size(), 0);
    check(mem[41] == 8'h02, "R2 fields decode add/store", int'(mem[41]), 2);
    check(mem[42] == 8'h02, "R3 pc wraps 63 to 0", int'(mem[42]), 2);
    check(mem_addr == 6'd2, "R7 halt at 2", int'(mem_addr), 2);

    // reset part way through program A, then full rerun
    enter_reset();
    load_prog_a();
    push_prog_a();
    rst_n = 1'b1;
    repeat (15) @(negedge clk);
    enter_reset();
    check_reset("R1 mid-run reset");
    load_prog_a();
    push_prog_a();
    rst_n = 1'b1;
    repeat (200) @(negedge clk);
    check(exp_q.size() == 0, "R1 rerun stores seen", exp_q.size(), 0);
    check(mem[35] == 8'hFF, "R1 rerun final store", int'(mem[35]), 8'hFF);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule